// File: doc/BRIEF.md
# Memory Sleep Entry and Exit Sequencer

This block controls the low-power rest state of a synchronous memory. A sleep request arrives on a pin that has no timing relation to the memory clock. The block passes that pin through a chain of synchronizing flops. It then steps a four-phase sequencer through fixed-length entry and recovery windows. Two outputs drive the rest of the memory. A power-down indication is high while the memory rests. An access enable is high only when the memory is fully awake. A gated access start combines the access enable with the incoming select and strobe, so that no read or write can begin while the memory is asleep or recovering.

An access that is still in flight when entry begins is dropped. Once entry has started it always runs to the end. The protocol requires the memory to be deselected whenever sleep is requested and during the recovery window. The block watches the select and strobe inputs and raises a protocol-error pulse when either one is active at the wrong time. The stored contents are not affected by any phase, and the array itself is outside this block.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: While reset is held, and right after it is released with the request low, the phase output reads 0 (awake), access enable is 1, power-down is 0 and protocol error is 0. Phase codes are: 0 awake, 1 entering, 2 asleep, 3 exiting.
- R2: The request pin passes through SYNC_STAGES flops (default 2). With the defaults, a pin change made between two clock edges first moves the phase on the third rising edge after the change.
- R3: Access enable is 1 exactly when the phase is 0. It is 0 in phases 1, 2 and 3.
- R4: Once the synchronized request is seen in phase 0, the phase is 1 for ENTRY_CYCLES cycles (default 2) and then becomes 2, where power-down is 1. Dropping the request during phase 1 does not cut entry short.
- R5: When the synchronized request is low in phase 2, the phase becomes 3 on the next edge. It then stays at 3 for EXIT_CYCLES cycles (default 2) before it returns to 0. Power-down is 1 only in phase 2.
- R6: If the synchronized request is high again while the phase is 3, the phase returns to 2 on the next edge.
- R7: The access start output equals select AND strobe AND access enable, combinationally. It is therefore 0 in every phase other than 0.
- R8: The protocol error output is 1 for the cycle that follows any cycle in which select or strobe was high while either the synchronized request was high or the phase was 3. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pin | input | 1 | Sleep request, asynchronous to clk |
| dev_sel | input | 1 | Combined chip-select active |
| addr_strobe | input | 1 | Either address strobe active |
| phase_o | output | 2 | Current phase code (0 awake, 1 entering, 2 asleep, 3 exiting) |
| access_en | output | 1 | High only when accesses may begin |
| power_down | output | 1 | High while resting |
| start_ok | output | 1 | Gated access start |
| proto_err | output | 1 | One-cycle pulse on a select or strobe violation |

## Verification
The bench targets five timing cases:
- **Synchronizer depth.** A design with a missing or extra synchronizer stage would move the phase one edge early or late.
- **Entry length.** A request that drops while entry is under way must still produce a full rest. A design that aborts entry would go straight back to awake.
- **Recovery pulse.** A one-cycle low pulse on the request must bounce the phase from exiting back to asleep. A design that ignores the request during recovery would wake up instead.
- **Window lengths.** Both windows are timed edge by edge, which exposes counters that are off by one.
- **Gated start and error pulse.** These are compared against a bench model on every cycle, which exposes a missing term in either expression.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE  = 2'd0,
    PH_ENTER  = 2'd1,
    PH_ASLEEP = 2'd2,
    PH_EXIT   = 2'd3
  } phase_e;

  // Width of a counter that has to reach max(a,b)-1.
  function automatic int cnt_bits(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 3) ? 1 : $clog2(m);
  endfunction

  // Phase transition; last marks the final cycle of a timed window.
  function automatic phase_e next_phase(input phase_e cur, input logic req,
                                        input logic last);
    phase_e nx;
    nx = cur;
    case (cur)
      PH_AWAKE:  if (req) nx = PH_ENTER;
      PH_ENTER:  if (last) nx = PH_ASLEEP;
      PH_ASLEEP: if (!req) nx = PH_EXIT;
      PH_EXIT:   if (req) nx = PH_ASLEEP;
                 else if (last) nx = PH_AWAKE;
      default:   nx = PH_AWAKE;
    endcase
    return nx;
  endfunction

  // A violation: the memory is touched while it should be left alone.
  function automatic logic is_violation(input logic touch, input logic req,
                                        input phase_e cur);
    return touch && (req || (cur == PH_EXIT));
  endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lp_phase_fsm.sv
module lp_phase_fsm
  import lp_sleep_pkg::*;
#(
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_s,
  output phase_e phase_q,
  output logic   win_last
);
  localparam int CNT_W = cnt_bits(ENTRY_CYCLES, EXIT_CYCLES);
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  phase_e           phase_d;

  always_comb begin
    win_last = 1'b0;
    if (phase_q == PH_ENTER) win_last = (cnt_q == ENTRY_LAST);
    if (phase_q == PH_EXIT)  win_last = (cnt_q == EXIT_LAST);
  end

  assign phase_d = next_phase(phase_q, req_s, win_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AWAKE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_d != phase_q) cnt_q <= '0;
      else if (!win_last)     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lp_guard.sv
module lp_guard
  import lp_sleep_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   dev_sel,
  input  logic   addr_strobe,
  input  logic   req_s,
  input  phase_e phase_q,
  output logic   err_q
);
  logic touch;
  assign touch = dev_sel | addr_strobe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= is_violation(touch, req_s, phase_q);
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
  import lp_sleep_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_pin,
  input  logic       dev_sel,
  input  logic       addr_strobe,
  output logic [1:0] phase_o,
  output logic       access_en,
  output logic       power_down,
  output logic       start_ok,
  output logic       proto_err
);
  logic   req_sync;
  phase_e state_q;
  logic   win_last;

  lp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(sleep_pin), .q(req_sync)
  );

  lp_phase_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_s(req_sync),
    .phase_q(state_q), .win_last(win_last)
  );

  lp_guard guard_i (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .addr_strobe(addr_strobe),
    .req_s(req_sync), .phase_q(state_q), .err_q(proto_err)
  );

  assign phase_o    = state_q;
  assign access_en  = (state_q == PH_AWAKE);
  assign power_down = (state_q == PH_ASLEEP);
  assign start_ok   = dev_sel & addr_strobe & access_en;
endmodule

// File: rtl/lp_sleep_ctrl_chk.sv
module lp_sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_pin,
  input logic       dev_sel,
  input logic       addr_strobe,
  input logic       req_sync,
  input logic [1:0] phase_o,
  input logic       access_en,
  input logic       power_down,
  input logic       start_ok,
  input logic       proto_err
);
  a_r2_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_sync) |-> $past(sleep_pin, 2));

  a_r3_rest_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> !access_en);

  a_r4_awake_exits_via_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0) |=> (phase_o == 2'd0 || phase_o == 2'd1));

  a_r5_no_wake_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2) |=> (phase_o == 2'd2 || phase_o == 2'd3));

  a_r6_recovery_back_to_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && req_sync) |=> (phase_o == 2'd2));

  a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (access_en && !power_down));

  a_r8_flag_on_touch: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_sel || addr_strobe) && req_sync) |=> proto_err);
endmodule

bind lp_sleep_ctrl lp_sleep_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .dev_sel(dev_sel),
  .addr_strobe(addr_strobe), .req_sync(req_sync), .phase_o(phase_o),
  .access_en(access_en), .power_down(power_down), .start_ok(start_ok),
  .proto_err(proto_err)
);

// File: tb/lp_sleep_ctrl_tb_top.sv
module lp_sleep_ctrl_tb_top;
  localparam int ENTRY = 2;
  localparam int EXITN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_pin = 1'b0, dev_sel = 1'b0, addr_strobe = 1'b0;
  logic [1:0] phase_o;
  logic access_en, power_down, start_ok, proto_err;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lp_sleep_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .dev_sel(dev_sel),
    .addr_strobe(addr_strobe), .phase_o(phase_o), .access_en(access_en),
    .power_down(power_down), .start_ok(start_ok), .proto_err(proto_err)
  );

  // Bench model: delay line for the pin and a countdown per window.
  logic m_d1 = 0, m_d2 = 0, m_err = 0;
  int   m_ph = 0, m_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d1 <= 0; m_d2 <= 0; m_err <= 0; m_ph <= 0; m_left <= 0;
    end else begin
      m_d1  <= sleep_pin;
      m_d2  <= m_d1;
      m_err <= (dev_sel || addr_strobe) && (m_d2 || m_ph == 3);
      case (m_ph)
        0: if (m_d2) begin m_ph <= 1; m_left <= ENTRY - 1; end
        1: if (m_left == 0) m_ph <= 2; else m_left <= m_left - 1;
        2: if (!m_d2) begin m_ph <= 3; m_left <= EXITN - 1; end
        default: if (m_d2) m_ph <= 2;
                 else if (m_left == 0) m_ph <= 0;
                 else m_left <= m_left - 1;
      endcase
    end
  end

  function automatic logic exp_start(int ph, logic s, logic b);
    return s && b && (ph == 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R5 phase", phase_o, m_ph);
    chk("R3 access_en", access_en, (m_ph == 0));
    chk("R5 power_down", power_down, (m_ph == 2));
    chk("R7 start_ok", start_ok, exp_start(m_ph, dev_sel, addr_strobe));
    chk("R8 proto_err", proto_err, m_err);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    step(3);
    chk("R1 reset phase", phase_o, 0);
    chk("R1 reset access_en", access_en, 1);
    rst_n = 1'b1;
    step(2);
    chk("R1 phase", phase_o, 0);
    chk("R1 power_down", power_down, 0);
    chk("R1 proto_err", proto_err, 0);

    // R2/R4: entry timing.
    sleep_pin = 1'b1;
    step(2); chk("R2 still awake", phase_o, 0);
    step(1); chk("R2 entering on third edge", phase_o, 1);
    chk("R3 blocked while entering", access_en, 0);
    step(1); chk("R4 entry second cycle", phase_o, 1);
    step(1); chk("R4 asleep", phase_o, 2);
    chk("R4 power_down", power_down, 1);

    // R8: touch while request high.
    dev_sel = 1'b1; step(1);
    chk("R8 err pulse", proto_err, 1);
    chk("R7 no start asleep", start_ok, 0);
    dev_sel = 1'b0; step(1);
    chk("R8 err clears", proto_err, 0);

    // R6: one-cycle low pulse bounces recovery back to rest.
    sleep_pin = 1'b0; step(1); sleep_pin = 1'b1;
    step(1); chk("R6 still asleep", phase_o, 2);
    step(1); chk("R6 exiting", phase_o, 3);
    step(1); chk("R6 back asleep", phase_o, 2);

    // R5: exit timing.
    step(3);
    sleep_pin = 1'b0;
    step(2); chk("R5 still asleep", phase_o, 2);
    step(1); chk("R5 exiting", phase_o, 3);
    chk("R5 power_down low", power_down, 0);
    step(1); chk("R5 exit second cycle", phase_o, 3);
    step(1); chk("R5 awake", phase_o, 0);
    chk("R3 access back", access_en, 1);

    // R4: request dropped during entry does not abort it.
    sleep_pin = 1'b1; step(3);
    chk("R4 entering", phase_o, 1);
    sleep_pin = 1'b0;
    step(2); chk("R4 no abort", phase_o, 2);

    // Random traffic against the model.
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      cmp_model();
      if ($urandom_range(0, 11) == 0) sleep_pin = ~sleep_pin;
      dev_sel     = ($urandom_range(0, 3) == 0);
      addr_strobe = ($urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule